// File: doc/BRIEF.md
# External Interrupt Request Status Controller

This block watches six external interrupt request pins. For each pin it detects one condition that software selects: a low level, a falling edge, a rising edge or either edge. A detected condition sets a sticky flag in an 8-bit status register. Each flag, gated by a per-channel enable bit, drives one interrupt request output towards the interrupt controller. Priority arbitration and vector generation are left to that controller.

A flag is cleared in one of three ways:
- The host reads the flag as one and then writes a zero to it.
- The interrupt controller acknowledges the channel. In low-level mode this clears the flag only while the synchronised pin is high; in the edge modes it always clears the flag.
- A transfer controller strobes the channel while its keep-flag qualifier is low.

A hardware-standby input wipes the flags. A software-standby input keeps them intact.

The host reaches four byte-wide registers through a simple read and write strobe interface. Read data is combinational on the address. Only a read strobe arms a flag for the write-zero clear.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Register map on `bus_addr`: 0 holds the status flags, 1 the request enables, 2 the sense high bits and 3 the sense low bits. Channel n uses bit n of every register. Bits 7 and 6 of every register always read as 0.
- R2: Reset and `hw_standby` clear the status register to 0x00. While `sw_standby` is high, no flag is cleared.
- R3: The mode of channel n is {sense high bit n, sense low bit n}, and 00 is low level. In that mode flag n sets while the pin is low. A pin change driven between clock edges shows in the status register after the third rising edge: two synchroniser stages, then the flag register.
- R4: With mode 01, flag n sets on a falling edge of the pin and ignores a rising edge.
- R5: With mode 10, flag n sets on a rising edge of the pin and ignores a falling edge.
- R6: With mode 11, flag n sets on either edge of the pin.
- R7: Writing 1 to a flag has no effect. Writing 0 to a flag that has not been read as 1 since it was last cleared has no effect.
- R8: A read strobe at address 0 that returns 1 in bit n arms flag n. A later write of 0 to bit n then clears it. A write of 0 that clears flag n uses up the arming, so a flag that sets again needs a fresh read before a write of 0 clears it.
- R9: An acknowledge on `int_ack[n]` in low-level mode clears flag n only when the synchronised pin is high.
- R10: An acknowledge on `int_ack[n]` in any edge mode clears flag n, whatever the pin level.
- R11: A strobe on `xfer_start[n]` clears flag n when `xfer_keep_flag` is 0 and has no effect when it is 1.
- R12: When a set condition and a clear event hit the same flag in the same cycle, the flag is 1 afterwards.
- R13: `irq_req[n]` is flag n AND enable bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby; clears the flags |
| sw_standby | input | 1 | Software standby; flags are kept and clears are held off |
| irq_pin | input | 6 | Asynchronous interrupt request pins |
| bus_rd | input | 1 | Read strobe; arms the flags read as one |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| int_ack | input | 6 | Per-channel interrupt acknowledge |
| xfer_start | input | 6 | Per-channel transfer activation strobe |
| xfer_keep_flag | input | 1 | When high, transfer strobes leave the flags set |
| irq_req | output | 6 | Per-channel interrupt request |

## Verification
The bench builds the block with its defaults: six channels, an 8-bit register width and two synchroniser stages. That fixes the pin-to-flag latency at three edges, so the bench can place an acknowledge in exactly the cycle in which an edge detection lands, which is how the set-beats-clear case is reached. The default mapping sets up two level channels and channels in each edge mode side by side. This lets each mode show that it ignores the edges it does not select while the other channels stay quiet.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_STAT  = 2'd0;
  localparam logic [1:0] ADDR_EN    = 2'd1;
  localparam logic [1:0] ADDR_SENSH = 2'd2;
  localparam logic [1:0] ADDR_SENSL = 2'd3;

  // Set condition for one channel from the current and previous synced level.
  function automatic logic sense_hit(sense_e mode, logic cur, logic prev);
    logic fell, rose;
    fell = prev & ~cur;
    rose = ~prev & cur;
    case (mode)
      SENSE_LOW:  sense_hit = ~cur;
      SENSE_FALL: sense_hit = fell;
      SENSE_RISE: sense_hit = rose;
      default:    sense_hit = fell | rose;
    endcase
  endfunction

  // Whether an acknowledge may clear the flag.
  function automatic logic ack_allowed(sense_e mode, logic cur);
    ack_allowed = (mode != SENSE_LOW) | cur;
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '1;
          else        stg_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '1;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign cur  = stg_q[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/irq_sense_detect.sv
module irq_sense_detect
  import irq_flag_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic [NCH-1:0] sense_hi,
  input  logic [NCH-1:0] sense_lo,
  input  logic [NCH-1:0] cur,
  input  logic [NCH-1:0] prev,
  output logic [NCH-1:0] hit,
  output logic [NCH-1:0] ack_ok
);
  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_ch
      sense_e mode_w;
      assign mode_w    = sense_e'({sense_hi[n], sense_lo[n]});
      assign hit[n]    = sense_hit(mode_w, cur[n], prev[n]);
      assign ack_ok[n] = ack_allowed(mode_w, cur[n]);
    end
  endgenerate
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hw_standby,
  input  logic           hold,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] ack_clr,
  input  logic [NCH-1:0] xfer_clr,
  input  logic [NCH-1:0] rd_one,
  input  logic [NCH-1:0] wr_zero,
  output logic [NCH-1:0] flag_q,
  output logic [NCH-1:0] armed_q,
  output logic [NCH-1:0] clr_vec
);
  logic [NCH-1:0] wr_clr;
  logic [NCH-1:0] flag_d;
  logic [NCH-1:0] armed_d;

  always_comb begin
    wr_clr  = wr_zero & armed_q & {NCH{~hold}};
    clr_vec = (wr_clr | ack_clr | xfer_clr) & {NCH{~hold}};
    // a new set condition overrides any clear
    flag_d  = set_vec | (flag_q & ~clr_vec);
    armed_d = (armed_q | rd_one) & ~wr_clr & flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else if (hw_standby) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int NCH         = 6,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hw_standby,
  input  logic           sw_standby,
  input  logic [NCH-1:0] irq_pin,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] int_ack,
  input  logic [NCH-1:0] xfer_start,
  input  logic           xfer_keep_flag,
  output logic [NCH-1:0] irq_req
);
  localparam int RSV = DW - NCH;

  logic [NCH-1:0] en_q, sh_q, sl_q;
  logic [NCH-1:0] pin_cur, pin_prev;
  logic [NCH-1:0] set_vec, ack_ok, ack_clr, xfer_clr;
  logic [NCH-1:0] rd_one, wr_zero;
  logic [NCH-1:0] flag_q, armed_q, clr_vec;
  logic           wr_stat, rd_stat;
  logic           unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:NCH];

  irq_pin_sync #(.W(NCH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin(irq_pin), .cur(pin_cur), .prev(pin_prev)
  );

  irq_sense_detect #(.NCH(NCH)) det_i (
    .sense_hi(sh_q), .sense_lo(sl_q), .cur(pin_cur), .prev(pin_prev),
    .hit(set_vec), .ack_ok(ack_ok)
  );

  assign wr_stat  = bus_wr && (bus_addr == ADDR_STAT);
  assign rd_stat  = bus_rd && (bus_addr == ADDR_STAT);
  assign rd_one   = rd_stat ? flag_q : '0;
  assign wr_zero  = {NCH{wr_stat}} & ~bus_wdata[NCH-1:0];
  assign ack_clr  = int_ack & ack_ok;
  assign xfer_clr = xfer_start & {NCH{~xfer_keep_flag}};

  irq_flag_bank #(.NCH(NCH)) bank_i (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .hold(sw_standby),
    .set_vec(set_vec), .ack_clr(ack_clr), .xfer_clr(xfer_clr),
    .rd_one(rd_one), .wr_zero(wr_zero),
    .flag_q(flag_q), .armed_q(armed_q), .clr_vec(clr_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      sh_q <= '0;
      sl_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_EN:    en_q <= bus_wdata[NCH-1:0];
        ADDR_SENSH: sh_q <= bus_wdata[NCH-1:0];
        ADDR_SENSL: sl_q <= bus_wdata[NCH-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_STAT:  bus_rdata = {{RSV{1'b0}}, flag_q};
      ADDR_EN:    bus_rdata = {{RSV{1'b0}}, en_q};
      ADDR_SENSH: bus_rdata = {{RSV{1'b0}}, sh_q};
      default:    bus_rdata = {{RSV{1'b0}}, sl_q};
    endcase
  end

  assign irq_req = flag_q & en_q;
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk #(
  parameter int NCH = 6,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hw_standby,
  input logic           sw_standby,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] set_vec,
  input logic [NCH-1:0] clr_vec,
  input logic [NCH-1:0] flag_q,
  input logic [NCH-1:0] armed_q,
  input logic [NCH-1:0] irq_req
);
  // R1
  rsv_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NCH] == '0);

  // R2
  hw_standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> (flag_q == '0) && (armed_q == '0));

  // R2
  sw_standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_standby && !hw_standby) |=> (($past(flag_q) & ~flag_q) == '0));

  // R7
  flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_standby |=> ((($past(flag_q) & ~flag_q) & ~$past(clr_vec)) == '0));

  // R8
  armed_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q & ~flag_q) == '0);

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_vec) && !hw_standby) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R13
  req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~flag_q) == '0);
endmodule

bind irq_flag_ctrl irq_flag_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
  .bus_rdata(bus_rdata), .set_vec(set_vec), .clr_vec(clr_vec),
  .flag_q(flag_q), .armed_q(armed_q), .irq_req(irq_req)
);

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
  localparam int NCH = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           hw_standby = 1'b0, sw_standby = 1'b0;
  logic [NCH-1:0] irq_pin = '1;
  logic           bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]     bus_addr = 2'd0;
  logic [7:0]     bus_wdata = 8'h00;
  logic [7:0]     bus_rdata;
  logic [NCH-1:0] int_ack = '0, xfer_start = '0;
  logic           xfer_keep_flag = 1'b0;
  logic [NCH-1:0] irq_req;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
    .irq_pin(irq_pin), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_ack(int_ack),
    .xfer_start(xfer_start), .xfer_keep_flag(xfer_keep_flag), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(output logic [7:0] d);
    bus_addr = 2'd0; #1 d = bus_rdata;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    rd(2'd0, d); wr(2'd0, 8'h00);
  endtask

  task automatic pulse_ack(input logic [NCH-1:0] m);
    @(negedge clk); int_ack = m; @(negedge clk); int_ack = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(d); chk("R2 reset status", d, 8'h00);
    chk("R2 reset req", {2'b00, irq_req}, 8'h00);
    rd(2'd1, d); chk("R1 reset enable", d, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] d;
    // ch0 low, ch1 fall, ch2 rise, ch3 both, ch4 low, ch5 fall
    wr(2'd2, 8'hCC); wr(2'd3, 8'hEA);
    rd(2'd2, d); chk("R1 sense high readback", d, 8'h0C);
    rd(2'd3, d); chk("R1 sense low readback", d, 8'h2A);
    cyc(2); peek(d); chk("R3 no set with pins high", d, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    @(negedge clk); irq_pin[0] = 1'b0;
    @(negedge clk); peek(d); chk("R3 latency edge1", d, 8'h00);
    @(negedge clk); peek(d); chk("R3 latency edge2", d, 8'h00);
    @(negedge clk); peek(d); chk("R3 low sets edge3", d, 8'h01);
    irq_pin[0] = 1'b1; cyc(4); peek(d); chk("R3 flag sticky", d, 8'h01);
    clear_all(); peek(d); chk("R8 level clear", d, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    irq_pin[1] = 1'b0; cyc(4); peek(d); chk("R4 falling sets", d, 8'h02);
    clear_all();
    irq_pin[1] = 1'b1; cyc(4); peek(d); chk("R4 rising ignored", d, 8'h00);
    irq_pin[2] = 1'b0; cyc(4); peek(d); chk("R5 falling ignored", d, 8'h00);
    irq_pin[2] = 1'b1; cyc(4); peek(d); chk("R5 rising sets", d, 8'h04);
    clear_all();
    irq_pin[3] = 1'b0; cyc(4); peek(d); chk("R6 both falling", d, 8'h08);
    clear_all();
    irq_pin[3] = 1'b1; cyc(4); peek(d); chk("R6 both rising", d, 8'h08);
    clear_all(); peek(d); chk("R8 edges cleared", d, 8'h00);
  endtask

  task automatic t_write_rules();
    logic [7:0] d;
    irq_pin[1] = 1'b0; cyc(4); irq_pin[1] = 1'b1; cyc(4);
    wr(2'd0, 8'h00); peek(d); chk("R7 write0 unarmed", d, 8'h02);
    rd(2'd0, d); chk("R8 read shows one", d, 8'h02);
    wr(2'd0, 8'hFF); peek(d); chk("R7 write1 no effect", d, 8'h02);
    wr(2'd0, 8'h00); peek(d); chk("R8 read then write0", d, 8'h00);
    irq_pin[1] = 1'b0; cyc(4); irq_pin[1] = 1'b1; cyc(4);
    wr(2'd0, 8'h00); peek(d); chk("R8 arming consumed", d, 8'h02);
    clear_all();
  endtask

  task automatic t_ack();
    logic [7:0] d;
    irq_pin[0] = 1'b0; cyc(4);
    pulse_ack(6'h01); peek(d); chk("R9 ack while low", d, 8'h01);
    irq_pin[0] = 1'b1; cyc(4);
    pulse_ack(6'h01); peek(d); chk("R9 ack while high", d, 8'h00);
    irq_pin[1] = 1'b0; cyc(4); irq_pin[1] = 1'b1; cyc(4);
    pulse_ack(6'h02); peek(d); chk("R10 ack falling mode", d, 8'h00);
    irq_pin[3] = 1'b0; cyc(4);
    pulse_ack(6'h08); peek(d); chk("R10 ack edge pin low", d, 8'h00);
    irq_pin[3] = 1'b1; cyc(4); clear_all();
  endtask

  task automatic t_xfer();
    logic [7:0] d;
    irq_pin[2] = 1'b0; cyc(4); irq_pin[2] = 1'b1; cyc(4);
    @(negedge clk); xfer_keep_flag = 1'b1; xfer_start = 6'h04;
    @(negedge clk); xfer_start = '0;
    peek(d); chk("R11 strobe kept", d, 8'h04);
    @(negedge clk); xfer_keep_flag = 1'b0; xfer_start = 6'h04;
    @(negedge clk); xfer_start = '0;
    peek(d); chk("R11 strobe clears", d, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk); irq_pin[3] = 1'b0;
    @(negedge clk);
    @(negedge clk); int_ack = 6'h08;
    @(negedge clk); int_ack = '0;
    peek(d); chk("R12 set beats ack", d, 8'h08);
    pulse_ack(6'h08); peek(d); chk("R10 ack alone clears", d, 8'h00);
    irq_pin[3] = 1'b1; cyc(4); clear_all();
  endtask

  task automatic t_req();
    logic [7:0] d;
    irq_pin[1] = 1'b0; cyc(4); irq_pin[1] = 1'b1;
    irq_pin[3] = 1'b0; cyc(4);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R1 enable reserved", d, 8'h3F);
    chk("R13 all enabled", {2'b00, irq_req}, 8'h0A);
    wr(2'd1, 8'h02); chk("R13 partial enable", {2'b00, irq_req}, 8'h02);
  endtask

  task automatic t_standby();
    logic [7:0] d;
    @(negedge clk); sw_standby = 1'b1;
    rd(2'd0, d); wr(2'd0, 8'h00); pulse_ack(6'h0A);
    @(negedge clk); xfer_start = 6'h0A; @(negedge clk); xfer_start = '0;
    peek(d); chk("R2 sw standby keeps", d, 8'h0A);
    sw_standby = 1'b0;
    @(negedge clk); hw_standby = 1'b1; @(negedge clk); hw_standby = 1'b0;
    peek(d); chk("R2 hw standby clears", d, 8'h00);
    chk("R13 req after standby", {2'b00, irq_req}, 8'h00);
  endtask

  initial begin
    cyc(5); rst_n = 1'b1; cyc(2);
    t_reset();
    t_config();
    t_level();
    t_edges();
    t_write_rules();
    t_ack();
    t_xfer();
    t_set_wins();
    t_req();
    t_standby();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule